// File: doc/BRIEF.md
# Video DRAM Read-Transfer Sequencer

This block steps the control pins of a dual-port video DRAM through one memory-to-register (read) transfer. In a read transfer, a row of the random-access array is copied into the serial register. A requester presents a row address, a column (tap) address and a transfer variant, then raises `req`. The sequencer then marks the cycle as a transfer by pulling TRG low before RAS falls. It applies the row and column addresses and raises TRG at the moment the chosen variant allows. It also decides when the serial clock may toggle. Finally it precharges RAS and pulses `done`.

Three variants are supported. Early-load keeps serial clocking stopped until the transfer has fully settled. Real-time reload lets serial clocking run through the cycle and raises TRG inside a short quiet window, so the serial register reloads on the fly. Late-load also keeps the serial clock running, but it raises TRG as early as the CAS timing permits. Every interval is a nanosecond parameter. It is turned into a whole number of system clocks by rounding up, with a floor of one clock.

Serial clocking is not driven here. The block outputs `sc_en`, and the serial clock may only have rising edges while `sc_en` is high.

Top module: `vrt_seq`

## Requirements
- R1: After reset, and whenever no transfer is in progress, the outputs are RAS, CAS and TRG high (all active-low, so inactive), `sc_en` high, `busy` low and `done` low.
- R2: A request is taken only while the sequencer is idle. Raising `req` with other addresses or another variant during a transfer changes nothing in that transfer.
- R3: For the first ceil(10 ns/clk) cycles of a transfer, TRG is low, RAS is still high, `sc_en` is low and the row address is on `addr`. RAS falls only after this window, so no serial edge lands just before RAS falls.
- R4: RAS stays low with the row address for ceil(15 ns/clk) cycles. Then the column address appears and CAS falls in the same cycle.
- R5: Early-load (variant code 0) keeps serial clocking stopped in every cycle of the transfer. `sc_en` rises only after all of these have passed: ceil(130 ns/clk) cycles from RAS falling, ceil(40 ns/clk) from CAS falling and ceil(45 ns/clk) from column address valid. TRG rises before `sc_en` is released.
- R6: Real-time reload (variant code 1) raises TRG at least ceil(90 ns/clk) cycles after RAS falls, at least ceil(5 ns/clk) after CAS falls and at least ceil(10 ns/clk) after column address valid. Serial clocking is allowed from RAS low until the quiet window.
- R7: In real-time reload and late-load (variant code 2), `sc_en` is high while RAS is low before the quiet window. In every variant, `sc_en` is low for ceil(15 ns/clk) cycles before TRG rises and for ceil(35 ns/clk) cycles after it. Late-load holds CAS low for ceil(5 ns/clk) cycles before that window.
- R8: TRG rises before RAS rises, never after.
- R9: RAS and CAS then stay high for ceil(80 ns/clk) precharge cycles, with the row address on `addr` and `sc_en` high. This is followed by exactly one cycle with `done` high, and then the sequencer is idle.
- R10: Variant code 3 is run as an early-load transfer.
- R11: `busy` is high in every cycle of a transfer, from the first guard cycle through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a read transfer (taken only when idle) |
| req_var | input | 2 | Variant: 0 early-load, 1 real-time reload, 2 late-load, 3 early-load |
| req_row | input | ADDR_W | Row address |
| req_col | input | ADDR_W | Column / serial tap address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| trg_n | output | 1 | Transfer / output-enable strobe, active low |
| sc_en | output | 1 | Serial clock permitted when high |
| addr | output | ADDR_W | Multiplexed DRAM address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The outputs are decoded from the registered state. A request sampled at a clock edge therefore shows its first guard cycle right after that same edge, and every later pin change lines up with a state-length boundary. The driver pushes one expected pin vector per cycle at the accepting edge. The monitor pops one vector at each falling edge, so every cycle of the trace is compared in the very cycle it is due. When the queue is empty, the same monitor checks the idle values. The checker adds counters that measure, in cycles, the distance from RAS falling to TRG or `sc_en` rising, and from TRG rising to `sc_en` release.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

    typedef enum logic [1:0] {
        XV_EARLY = 2'd0,
        XV_RT    = 2'd1,
        XV_LATE  = 2'd2
    } xfer_var_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_TRG_HOLD,
        ST_TRG_RISE,
        ST_SC_RELEASE,
        ST_PRECHARGE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic trg_n;
        logic sc_en;
    } pins_t;

    // nanoseconds to clocks, rounded up, never below one clock
    function automatic int ns2cyc(int ns, int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // code 3 has no variant of its own and falls back to early-load
    function automatic xfer_var_e decode_var(logic [1:0] code);
        case (code)
            2'd1:    return XV_RT;
            2'd2:    return XV_LATE;
            default: return XV_EARLY;
        endcase
    endfunction

    function automatic pins_t pins_for(seq_state_e st, xfer_var_e v);
        pins_t p;
        logic  run;
        run = (v != XV_EARLY);
        p   = '{ras_n: 1'b1, cas_n: 1'b1, trg_n: 1'b1, sc_en: 1'b1};
        case (st)
            ST_ROW:        p = '{ras_n: 1'b1, cas_n: 1'b1, trg_n: 1'b0, sc_en: 1'b0};
            ST_COL:        p = '{ras_n: 1'b0, cas_n: 1'b1, trg_n: 1'b0, sc_en: run};
            ST_TRG_HOLD:   p = '{ras_n: 1'b0, cas_n: 1'b0, trg_n: 1'b0, sc_en: run};
            ST_TRG_RISE:   p = '{ras_n: 1'b0, cas_n: 1'b0, trg_n: 1'b0, sc_en: 1'b0};
            ST_SC_RELEASE: p = '{ras_n: 1'b0, cas_n: 1'b0, trg_n: 1'b1, sc_en: 1'b0};
            default:       p = '{ras_n: 1'b1, cas_n: 1'b1, trg_n: 1'b1, sc_en: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/vrt_timer.sv
module vrt_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    assign expire = (cnt == len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vrt_fsm.sv
module vrt_fsm
    import vrt_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int CNT_W       = 4,
    parameter int L_ROW       = 1,
    parameter int L_COL       = 2,
    parameter int L_HOLD_FAST = 1,
    parameter int L_HOLD_RT   = 5,
    parameter int L_RISE      = 2,
    parameter int L_REL_EARLY = 8,
    parameter int L_REL_RUN   = 4,
    parameter int L_PRE       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        req_var,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [ADDR_W-1:0] req_col,
    input  logic              expire,
    output seq_state_e        state,
    output xfer_var_e         cur_var,
    output logic [ADDR_W-1:0] row_q,
    output logic [ADDR_W-1:0] col_q,
    output logic [CNT_W-1:0]  seg_len,
    output logic              restart
);
    seq_state_e nxt;
    logic       accept;
    logic       advance;

    assign accept  = (state == ST_IDLE) && req;
    assign advance = (state != ST_IDLE) && expire;
    assign restart = accept || advance;

    always_comb begin
        case (state)
            ST_IDLE:       nxt = ST_ROW;
            ST_ROW:        nxt = ST_COL;
            ST_COL:        nxt = ST_TRG_HOLD;
            ST_TRG_HOLD:   nxt = ST_TRG_RISE;
            ST_TRG_RISE:   nxt = ST_SC_RELEASE;
            ST_SC_RELEASE: nxt = ST_PRECHARGE;
            ST_PRECHARGE:  nxt = ST_DONE;
            default:       nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        case (state)
            ST_ROW:        seg_len = CNT_W'(L_ROW);
            ST_COL:        seg_len = CNT_W'(L_COL);
            ST_TRG_HOLD:   seg_len = (cur_var == XV_RT) ? CNT_W'(L_HOLD_RT)
                                                        : CNT_W'(L_HOLD_FAST);
            ST_TRG_RISE:   seg_len = CNT_W'(L_RISE);
            ST_SC_RELEASE: seg_len = (cur_var == XV_EARLY) ? CNT_W'(L_REL_EARLY)
                                                           : CNT_W'(L_REL_RUN);
            ST_PRECHARGE:  seg_len = CNT_W'(L_PRE);
            default:       seg_len = CNT_W'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur_var <= XV_EARLY;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            if (restart) begin
                state <= nxt;
            end
            if (accept) begin
                cur_var <= decode_var(req_var);
                row_q   <= req_row;
                col_q   <= req_col;
            end
        end
    end
endmodule

// File: rtl/vrt_pindrv.sv
module vrt_pindrv
    import vrt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  seq_state_e        state,
    input  xfer_var_e         cur_var,
    input  logic [ADDR_W-1:0] row_q,
    input  logic [ADDR_W-1:0] col_q,
    output pins_t             pins,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done
);
    logic col_phase;

    assign col_phase = (state == ST_TRG_HOLD) || (state == ST_TRG_RISE) ||
                       (state == ST_SC_RELEASE);
    assign pins = pins_for(state, cur_var);
    assign addr = col_phase ? col_q : row_q;
    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);
endmodule

// File: rtl/vrt_seq.sv
module vrt_seq
    import vrt_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int CLK_NS    = 10,
    parameter int T_SRS_NS  = 10,
    parameter int T_RAD_NS  = 15,
    parameter int T_CTH_NS  = 5,
    parameter int T_ATH_NS  = 10,
    parameter int T_RTH_NS  = 90,
    parameter int T_TSL_NS  = 15,
    parameter int T_TSD_NS  = 35,
    parameter int T_RSD_NS  = 130,
    parameter int T_CSD_NS  = 40,
    parameter int T_ASD_NS  = 45,
    parameter int T_RP_NS   = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        req_var,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [ADDR_W-1:0] req_col,
    output logic              ras_n,
    output logic              cas_n,
    output logic              trg_n,
    output logic              sc_en,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done
);
    localparam int C_SRS = ns2cyc(T_SRS_NS, CLK_NS);
    localparam int C_RAD = ns2cyc(T_RAD_NS, CLK_NS);
    localparam int C_CTH = ns2cyc(T_CTH_NS, CLK_NS);
    localparam int C_ATH = ns2cyc(T_ATH_NS, CLK_NS);
    localparam int C_RTH = ns2cyc(T_RTH_NS, CLK_NS);
    localparam int C_TSL = ns2cyc(T_TSL_NS, CLK_NS);
    localparam int C_TSD = ns2cyc(T_TSD_NS, CLK_NS);
    localparam int C_RSD = ns2cyc(T_RSD_NS, CLK_NS);
    localparam int C_CSD = ns2cyc(T_CSD_NS, CLK_NS);
    localparam int C_ASD = ns2cyc(T_ASD_NS, CLK_NS);
    localparam int C_RP  = ns2cyc(T_RP_NS,  CLK_NS);

    // CAS-low hold before the quiet window
    localparam int H_FAST = C_CTH;
    localparam int H_RT   = imax(C_CTH, imax(C_RTH - C_RAD - C_TSL, C_ATH - C_TSL));
    // serial gate hold after TRG rises
    localparam int R_EARLY = imax(imax(C_TSD, C_RSD - (C_RAD + H_FAST + C_TSL)),
                                  imax(C_CSD - (H_FAST + C_TSL),
                                       C_ASD - (H_FAST + C_TSL)));
    localparam int R_RUN  = C_TSD;
    localparam int L_MAX  = imax(imax(imax(C_SRS, C_RAD), imax(H_RT, C_TSL)),
                                 imax(imax(R_EARLY, R_RUN), C_RP));
    localparam int CNT_W  = $clog2(L_MAX + 1);

    seq_state_e        state;
    xfer_var_e         cur_var;
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;
    logic [CNT_W-1:0]  seg_len;
    logic              restart;
    logic              expire;
    pins_t             pins;

    vrt_fsm #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .L_ROW(C_SRS), .L_COL(C_RAD),
        .L_HOLD_FAST(H_FAST), .L_HOLD_RT(H_RT),
        .L_RISE(C_TSL), .L_REL_EARLY(R_EARLY), .L_REL_RUN(R_RUN),
        .L_PRE(C_RP)
    ) u_fsm (
        .clk(clk), .rst(rst), .req(req), .req_var(req_var),
        .req_row(req_row), .req_col(req_col), .expire(expire),
        .state(state), .cur_var(cur_var), .row_q(row_q), .col_q(col_q),
        .seg_len(seg_len), .restart(restart)
    );

    vrt_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .restart(restart), .len(seg_len), .expire(expire)
    );

    vrt_pindrv #(.ADDR_W(ADDR_W)) u_pins (
        .state(state), .cur_var(cur_var), .row_q(row_q), .col_q(col_q),
        .pins(pins), .addr(addr), .busy(busy), .done(done)
    );

    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign trg_n = pins.trg_n;
    assign sc_en = pins.sc_en;
endmodule

// File: rtl/vrt_seq_chk.sv
module vrt_seq_chk
    import vrt_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int T_RTH_NS = 90,
    parameter int T_RSD_NS = 130,
    parameter int T_TSD_NS = 35,
    parameter int T_TSL_NS = 15
) (
    input logic      clk,
    input logic      rst,
    input logic      ras_n,
    input logic      cas_n,
    input logic      trg_n,
    input logic      sc_en,
    input logic      busy,
    input logic      done,
    input xfer_var_e cur_var
);
    localparam int CW    = 8;
    localparam int C_RTH = ns2cyc(T_RTH_NS, CLK_NS);
    localparam int C_RSD = ns2cyc(T_RSD_NS, CLK_NS);
    localparam int C_TSD = ns2cyc(T_TSD_NS, CLK_NS);
    localparam int C_TSL = ns2cyc(T_TSL_NS, CLK_NS);

    logic [CW-1:0] ras_cnt;  // cycles since RAS fell
    logic [CW-1:0] trg_cnt;  // cycles since TRG rose
    logic [CW-1:0] gate_cnt; // consecutive cycles with sc_en low

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_cnt  <= '0;
            trg_cnt  <= '0;
            gate_cnt <= '0;
        end else begin
            ras_cnt  <= ras_n  ? '0 : ((&ras_cnt)  ? ras_cnt  : ras_cnt  + 1'b1);
            trg_cnt  <= !trg_n ? '0 : ((&trg_cnt)  ? trg_cnt  : trg_cnt  + 1'b1);
            gate_cnt <= sc_en  ? '0 : ((&gate_cnt) ? gate_cnt : gate_cnt + 1'b1);
        end
    end

    assert_guard_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!trg_n && $past(!sc_en)));

    assert_early_release_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(sc_en) && busy && cur_var == XV_EARLY) |-> (ras_cnt >= CW'(C_RSD)));

    assert_rt_trg_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(trg_n) && cur_var == XV_RT) |-> (ras_cnt >= CW'(C_RTH)));

    assert_quiet_before_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(trg_n) |-> (!sc_en && gate_cnt >= CW'(C_TSL)));

    assert_quiet_after_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(sc_en) && busy && trg_n) |-> (trg_cnt >= CW'(C_TSD)));

    assert_trg_first_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (trg_n && $past(trg_n)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !cas_n || !trg_n || done) |-> busy);
endmodule

bind vrt_seq vrt_seq_chk #(
    .CLK_NS(CLK_NS), .T_RTH_NS(T_RTH_NS), .T_RSD_NS(T_RSD_NS),
    .T_TSD_NS(T_TSD_NS), .T_TSL_NS(T_TSL_NS)
) u_chk (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .trg_n(trg_n),
    .sc_en(sc_en), .busy(busy), .done(done), .cur_var(cur_var)
);

// File: tb/vrt_seq_tb.sv
module vrt_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;
    localparam int WD_CYCLES  = 20000;

    function automatic int cyc(int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int bmax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int LR    = cyc(10);
    localparam int LC    = cyc(15);
    localparam int LRISE = cyc(15);
    localparam int HF    = cyc(5);
    localparam int HRT   = bmax(cyc(5), bmax(cyc(90) - LC - LRISE, cyc(10) - LRISE));
    localparam int RRUN  = cyc(35);
    localparam int REARLY = bmax(bmax(RRUN, cyc(130) - (LC + HF + LRISE)),
                                 bmax(cyc(40) - (HF + LRISE), cyc(45) - (HF + LRISE)));
    localparam int LP    = cyc(80);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic [1:0]    req_var = 2'd0;
    logic [AW-1:0] req_row = '0;
    logic [AW-1:0] req_col = '0;
    logic          ras_n, cas_n, trg_n, sc_en, busy, done;
    logic [AW-1:0] addr;

    typedef struct {
        logic [5:0]    ctl;   // {ras_n, cas_n, trg_n, sc_en, busy, done}
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vrt_seq #(.ADDR_W(AW), .CLK_NS(CLK_PERIOD)) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_var(req_var),
        .req_row(req_row), .req_col(req_col),
        .ras_n(ras_n), .cas_n(cas_n), .trg_n(trg_n), .sc_en(sc_en),
        .addr(addr), .busy(busy), .done(done)
    );

    task automatic check(bit ok, string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic string tg(string dflt, string force_tag);
        return (force_tag == "") ? dflt : force_tag;
    endfunction

    task automatic seg(int n, logic r, logic c, logic t, logic s,
                       logic [AW-1:0] a, logic d, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.ctl  = {r, c, t, s, 1'b1, d};
            e.addr = a;
            e.tag  = tag;
            q.push_back(e);
        end
    endtask

    // expected per-cycle pins; codes 0 and 3 early, 1 real-time, 2 late
    task automatic push_trace(logic [1:0] code, logic [AW-1:0] row,
                              logic [AW-1:0] col, string ft);
        logic  run;
        int    h, rel;
        string mid;
        run = (code == 2'd1) || (code == 2'd2);
        h   = (code == 2'd1) ? HRT : HF;
        rel = run ? RRUN : REARLY;
        mid = (code == 2'd1) ? "R6" : (code == 2'd2) ? "R7" : "R5";
        seg(LR,     1, 1, 0, 0,   row, 0, tg("R3", ft));
        seg(LC,     0, 1, 0, run, row, 0, tg("R4", ft));
        seg(h,      0, 0, 0, run, col, 0, tg(mid, ft));
        seg(LRISE,  0, 0, 0, 0,   col, 0, tg("R7", ft));
        seg(rel,    0, 0, 1, 0,   col, 0, tg(mid, ft));
        seg(1,      1, 1, 1, 1,   row, 0, tg("R8", ft));
        seg(LP - 1, 1, 1, 1, 1,   row, 0, tg("R9", ft));
        seg(1,      1, 1, 1, 1,   row, 1, tg("R9/R11", ft));
    endtask

    task automatic run_xfer(logic [1:0] code, logic [AW-1:0] row,
                            logic [AW-1:0] col, bit spam, string ft);
        @(negedge clk);
        req = 1'b1; req_var = code; req_row = row; req_col = col;
        @(posedge clk);
        push_trace(code, row, col, ft);
        #1 req = 1'b0;
        if (spam) begin
            // R2: requests while busy must not disturb the running trace
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                req = 1'b1; req_var = code ^ 2'd1; req_row = ~row; req_col = ~col;
            end
            @(negedge clk);
            req = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: one expected vector per busy cycle, idle values otherwise (R1)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [5:0] got;
            exp_t       e;
            got = {ras_n, cas_n, trg_n, sc_en, busy, done};
            if (q.size() > 0) begin
                e = q.pop_front();
                check(got == e.ctl && addr == e.addr, e.tag,
                      {got, addr}, {e.ctl, e.addr});
            end else begin
                check(got == 6'b111100, "R1", {got, addr}, {6'b111100, addr});
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R11 got=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        run_xfer(2'd0, 10'h155, 10'h0AA, 1'b0, "");    // R5 early-load
        run_xfer(2'd1, 10'h2C3, 10'h13C, 1'b0, "");    // R6 real-time reload
        run_xfer(2'd2, 10'h0F0, 10'h30F, 1'b0, "");    // R7 late-load
        run_xfer(2'd3, 10'h3FF, 10'h001, 1'b0, "R10"); // code 3 as early
        run_xfer(2'd1, 10'h001, 10'h3FE, 1'b1, "R2");
        run_xfer(2'd0, 10'h000, 10'h3FF, 1'b1, "R2");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule